// File: doc/BRIEF.md
# Line-Frequency Clock Interrupt Unit

This block is a memory-mapped clock device for a minicomputer bus. A periodic tick (typically derived from the mains frequency) sets a flag in a small control/status word. If software has set the enable bit, the tick also leaves an interrupt pending. The pending interrupt is offered to the processor only while the processor's current priority is below the device's fixed level.

When the processor acknowledges, the unit answers one cycle later with a strobe. The strobe carries the address of the vector word that holds the new program counter, and the address of the word after it that holds the new processor status. A bus-wide reset pulse, such as one a console start issues, turns the enable bit off and discards any pending interrupt.

Software reaches the control/status word through a plain read/write port. A read is combinational. A write takes effect at the next clock edge.

Top module: `lclk_irq_unit`

## Requirements
- R1: After reset, `irq_req` and `vec_stb` are 0, and a read of the control/status word returns 0.
- R2: The control/status word answers only at address 0o177546 while `reg_rd` is 1. Bit 6 reads the enable bit and bit 7 reads the tick flag, and all other bits read 0. Any other address, or `reg_rd` at 0, returns 0.
- R3: A write to the control/status address loads the enable bit from `reg_wdata[6]`. The new value reads back from the next cycle on.
- R4: A `tick` pulse sets the tick flag whatever the enable bit is. A tick while the enable bit is 0 raises no request.
- R5: A write with `reg_wdata[7]`=1 clears the tick flag, and a write with `reg_wdata[7]`=0 leaves it unchanged. A tick in the same cycle as a clearing write leaves the flag set.
- R6: A tick while the enable bit is 1 makes an interrupt pending. `irq_req` is 1 exactly while the interrupt is pending and `cpu_pri` (0..7) is below 6. The pending state persists until an accepted acknowledge.
- R7: Setting the enable bit while the tick flag is already 1 raises no request. Only a later tick does.
- R8: `irq_ack`=1 while `irq_req`=1 is an accepted acknowledge. In the next cycle `vec_stb` is 1 for one cycle, with `vec_pc_addr`=0o100 and `vec_ps_addr`=0o102. Both addresses are 0 whenever `vec_stb` is 0. The acknowledge clears the pending state, unless an enabled tick arrives in that same cycle, in which case the interrupt stays pending.
- R9: `irq_ack` while `irq_req` is 0 has no effect: no strobe follows, and a pending interrupt stays pending.
- R10: A `bus_init` pulse clears the enable bit and the pending state, taking priority over a write or tick in the same cycle. It leaves the tick flag unchanged.
- R11: A write that clears the enable bit also discards a pending interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_init | input | 1 | Bus-wide reset pulse |
| reg_addr | input | 16 | Register port address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read enable |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| tick | input | 1 | One-cycle line-frequency tick |
| cpu_pri | input | 3 | Current processor priority level |
| irq_req | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge from the processor |
| vec_stb | output | 1 | Vector strobe, one cycle after an accepted acknowledge |
| vec_pc_addr | output | 16 | Address of the new-PC vector word |
| vec_ps_addr | output | 16 | Address of the new-status vector word |

## Verification
The collision of interest is a fresh enabled tick landing in the same cycle as an accepted acknowledge. The bench provokes it by pulsing `tick` and `irq_ack` together while a request is up. It then expects the vector strobe in the following cycle and `irq_req` still high, so the new tick is not lost. Two other collisions are driven the same way: a tick meeting a flag-clearing write, and a bus reset meeting an enabling write. Each is judged by reading the status word back through the port.

// File: rtl/lclk_pkg.sv
package lclk_pkg;

    typedef struct packed {
        logic ie;
        logic flag;
    } lclk_csr_t;

    typedef struct packed {
        logic pend;
        logic vstb;
    } lclk_req_t;

endpackage

// File: rtl/lclk_csr.sv
module lclk_csr
    import lclk_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int          DATA_W   = 16,
    parameter logic [15:0] CSR_ADDR = 16'o177546,
    parameter int          IE_BIT   = 6,
    parameter int          FLAG_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_init,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              tick,
    output logic              ie_q_o,
    output logic              ie_d_o
);

    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(CSR_ADDR);

    lclk_csr_t csr_d, csr_q;
    logic      hit;

    assign hit = (reg_addr == HIT_ADDR);

    always_comb begin
        csr_d = csr_q;
        if (reg_wr && hit) begin
            csr_d.ie = reg_wdata[IE_BIT];
            if (reg_wdata[FLAG_BIT]) csr_d.flag = 1'b0;
        end
        if (tick)     csr_d.flag = 1'b1;
        if (bus_init) csr_d.ie   = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) csr_q <= '0;
        else        csr_q <= csr_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd && hit) begin
            reg_rdata[IE_BIT]   = csr_q.ie;
            reg_rdata[FLAG_BIT] = csr_q.flag;
        end
    end

    assign ie_q_o = csr_q.ie;
    assign ie_d_o = csr_d.ie;

    AST_INIT_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_init |=> !csr_q.ie); // R10
    AST_TICK_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> csr_q.flag); // R4

endmodule

// File: rtl/lclk_req.sv
module lclk_req
    import lclk_pkg::*;
#(
    parameter int          PRI_W    = 3,
    parameter int          DEV_PRI  = 6,
    parameter int          VA_W     = 16,
    parameter logic [15:0] VEC_ADDR = 16'o100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ie_q,
    input  logic             ie_d,
    input  logic [PRI_W-1:0] cpu_pri,
    input  logic             irq_ack,
    output logic             irq_req,
    output logic             vec_stb,
    output logic [VA_W-1:0]  vec_pc_addr,
    output logic [VA_W-1:0]  vec_ps_addr
);

    localparam logic [PRI_W-1:0] DEV_LVL = PRI_W'(DEV_PRI);
    localparam logic [VA_W-1:0]  PC_VA   = VA_W'(VEC_ADDR);
    localparam logic [VA_W-1:0]  PS_VA   = VA_W'(VEC_ADDR) + VA_W'(2);

    lclk_req_t st_d, st_q;
    logic      accept;

    assign irq_req = st_q.pend && (cpu_pri < DEV_LVL);
    assign accept  = irq_ack && irq_req;

    always_comb begin
        st_d      = st_q;
        st_d.pend = ie_d && ((tick && ie_q) || (st_q.pend && !accept));
        st_d.vstb = accept;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vec_stb     = st_q.vstb;
    assign vec_pc_addr = st_q.vstb ? PC_VA : '0;
    assign vec_ps_addr = st_q.vstb ? PS_VA : '0;

    AST_VEC_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req) |=> vec_stb); // R8
    AST_NO_STRAY_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_ack && irq_req) |=> !vec_stb); // R9
    AST_REQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ie_q); // R11
    AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && !irq_ack && ie_d) |=> st_q.pend); // R6

endmodule

// File: rtl/lclk_irq_unit.sv
module lclk_irq_unit (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_init,
    input  logic [15:0] reg_addr,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        tick,
    input  logic [2:0]  cpu_pri,
    output logic        irq_req,
    input  logic        irq_ack,
    output logic        vec_stb,
    output logic [15:0] vec_pc_addr,
    output logic [15:0] vec_ps_addr
);

    logic ie_q, ie_d;

    lclk_csr #(
        .ADDR_W   (16),
        .DATA_W   (16),
        .CSR_ADDR (16'o177546),
        .IE_BIT   (6),
        .FLAG_BIT (7)
    ) i_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_init  (bus_init),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .tick      (tick),
        .ie_q_o    (ie_q),
        .ie_d_o    (ie_d)
    );

    lclk_req #(
        .PRI_W    (3),
        .DEV_PRI  (6),
        .VA_W     (16),
        .VEC_ADDR (16'o100)
    ) i_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .ie_q        (ie_q),
        .ie_d        (ie_d),
        .cpu_pri     (cpu_pri),
        .irq_ack     (irq_ack),
        .irq_req     (irq_req),
        .vec_stb     (vec_stb),
        .vec_pc_addr (vec_pc_addr),
        .vec_ps_addr (vec_ps_addr)
    );

    AST_INIT_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_init |=> !irq_req); // R10

endmodule

// File: tb/test_lclk_irq_unit.sv
module test_lclk_irq_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_init = 1'b0;
    logic [15:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        tick = 1'b0;
    logic [2:0]  cpu_pri = '0;
    logic        irq_req;
    logic        irq_ack = 1'b0;
    logic        vec_stb;
    logic [15:0] vec_pc_addr;
    logic [15:0] vec_ps_addr;

    int n_chk = 0;
    int n_fail = 0;
    localparam logic [15:0] CSR = 16'o177546;

    always #2.5 clk = ~clk;

    lclk_irq_unit i_lclk_irq_unit (
        .clk(clk), .rst_n(rst_n), .bus_init(bus_init),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick(tick),
        .cpu_pri(cpu_pri), .irq_req(irq_req), .irq_ack(irq_ack),
        .vec_stb(vec_stb), .vec_pc_addr(vec_pc_addr), .vec_ps_addr(vec_ps_addr)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0o expected=%0o", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [15:0] d);
        reg_addr = CSR; reg_wdata = d; reg_wr = 1'b1;
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] d);
        reg_addr = a; reg_rd = 1'b1;
        #0.5;
        d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        cyc();
        tick = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] d;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1
        rd(CSR, d);
        chk("R1 rdata", d, 0);
        chk("R1 irq_req", irq_req, 0);
        chk("R1 vec_stb", vec_stb, 0);

        // R3 / R2: sweep enable values with low bits set, flag stays 0
        for (int v = 0; v < 4; v++) begin
            wr(16'(v[0]) << 6 | 16'(v[1]) << 7 | 16'hFF3F);
            rd(CSR, d);
            chk("R3 ie readback", d, v[0] ? 16'o100 : 0);
        end
        rd(16'o177544, d);
        chk("R2 other address", d, 0);
        reg_addr = CSR; #0.5;
        chk("R2 no read enable", reg_rdata, 0);

        // R4: tick with enable off
        wr(16'h0000);
        pulse_tick();
        rd(CSR, d);
        chk("R4 flag set", d, 16'o200);
        for (int p = 0; p < 8; p++) begin
            cpu_pri = 3'(p); #0.5;
            chk("R4 no request", irq_req, 0);
        end
        cpu_pri = 0;

        // R7: enable with flag already set
        wr(16'o100);
        cyc(); cyc();
        chk("R7 no request", irq_req, 0);
        rd(CSR, d);
        chk("R7 readback", d, 16'o300);

        // R5: W1C
        wr(16'o300);
        rd(CSR, d);
        chk("R5 flag cleared", d, 16'o100);

        // R6: enabled tick, priority sweep
        pulse_tick();
        for (int p = 0; p < 8; p++) begin
            cpu_pri = 3'(p); #0.5;
            chk("R6 gating", irq_req, (p < 6) ? 1 : 0);
        end
        cpu_pri = 0;
        repeat (4) cyc();
        chk("R6 held", irq_req, 1);

        // R9: ack while masked
        cpu_pri = 7; irq_ack = 1'b1;
        cyc();
        irq_ack = 1'b0;
        chk("R9 no strobe", vec_stb, 0);
        cpu_pri = 0; #0.5;
        chk("R9 still pending", irq_req, 1);

        // R8: accepted ack
        irq_ack = 1'b1;
        cyc();
        irq_ack = 1'b0;
        chk("R8 strobe", vec_stb, 1);
        chk("R8 pc addr", vec_pc_addr, 16'o100);
        chk("R8 ps addr", vec_ps_addr, 16'o102);
        chk("R8 req dropped", irq_req, 0);
        cyc();
        chk("R8 strobe one cycle", vec_stb, 0);
        chk("R8 pc addr idle", vec_pc_addr, 0);

        // R8 collision: tick and ack together
        pulse_tick();
        chk("R8 pending", irq_req, 1);
        tick = 1'b1; irq_ack = 1'b1;
        cyc();
        tick = 1'b0; irq_ack = 1'b0;
        chk("R8 collision strobe", vec_stb, 1);
        chk("R8 collision keeps request", irq_req, 1);
        irq_ack = 1'b1; cyc(); irq_ack = 1'b0;
        chk("R8 cleared", irq_req, 0);

        // R5 collision: tick with clearing write
        reg_addr = CSR; reg_wdata = 16'o300; reg_wr = 1'b1; tick = 1'b1;
        cyc();
        reg_wr = 1'b0; tick = 1'b0;
        rd(CSR, d);
        chk("R5 tick wins", d, 16'o300);
        wr(16'o300);
        rd(CSR, d);
        chk("R5 cleared again", d, 16'o100);
        wr(16'o100);
        rd(CSR, d);
        chk("R5 write zero keeps", d, 16'o100);

        // R11: disabling write drops request
        pulse_tick();
        chk("R11 pending", irq_req, 1);
        wr(16'o000);
        chk("R11 dropped", irq_req, 0);
        wr(16'o100);
        chk("R11 stays dropped", irq_req, 0);

        // R10: bus reset
        pulse_tick();
        chk("R10 pending", irq_req, 1);
        bus_init = 1'b1; cyc(); bus_init = 1'b0;
        chk("R10 req cleared", irq_req, 0);
        rd(CSR, d);
        chk("R10 ie cleared flag kept", d, 16'o200);
        reg_addr = CSR; reg_wdata = 16'o100; reg_wr = 1'b1; bus_init = 1'b1;
        cyc();
        reg_wr = 1'b0; bus_init = 1'b0;
        rd(CSR, d);
        chk("R10 beats write", d, 16'o200);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule